// File: doc/BRIEF.md
# Receive Descriptor Ring Sequencer with First-Descriptor Status Writeback

This block walks a ring of receive buffer descriptors while a packet stream arrives. Each accepted beat stands for one byte. Each descriptor offers a first buffer, meant for a short header, followed by a second buffer, meant for the body. Bytes fill the first buffer and then the second. When both are full and the packet continues, the packet spills into the next descriptor on the ring. A packet marked with a start flag always opens a descriptor of its own. The previous packet's last descriptor is never shared, even when it still has room.

When the end-of-packet beat is accepted, status goes into the packet's first descriptor and nowhere else. That status is a completion bit, an error bit and the stored length. As an option, the first-buffer size field is replaced by the number of descriptors the packet used. The completion bit appears only at that moment, so software can clear all status words and then scan for completed packets.

Software loads descriptors through a load port and reads them back through a read port. It grants descriptors by adding to a credit count. A channel enable restarts the ring at entry 0 each time it is turned on, and leaves the credit count alone. The stream input uses valid/ready. A beat transfers on a rising edge where both are high. `in_valid` may be held across stall cycles. `in_ready` depends only on internal state and `ch_en`, never on `in_valid`. It is low while the channel is off, during the first cycle after the channel turns on, and while no packet is open and the credit count is zero.

Top module: `rxdesc_status_writer`

## Requirements
- R1: A descriptor word is 30 bits. The fields are: bit 29 completion, bit 28 error, bits [27:16] length, bits [15:8] second-buffer size, bits [7:0] first-buffer size. `ld_en` writes `ld_word` into entry `ld_idx` on the next edge. `rd_word` shows entry `rd_idx` combinationally.
- R2: `in_ready` is low while `ch_en` is low and during the first cycle after `ch_en` rises. With no packet open, `in_ready` is high only when `cnt_level` is nonzero, so a stalled start beat is held rather than lost.
- R3: A descriptor holds first-buffer size plus second-buffer size bytes. A further byte of the same packet claims the next ring entry. `cnt_level` drops by one for each claimed entry and rises by `cnt_add_num` on a cycle with `cnt_add` high.
- R4: A start beat accepted with no packet open always claims a new ring entry, even when the previous packet left room in its last entry.
- R5: On an accepted end beat, the packet's first entry gets completion=1, error=0 and length=bytes stored. Its second-buffer size is unchanged, and the packet's other entries are not written.
- R6: The completion bit of a packet's first entry stays at its loaded value until the packet's end beat is accepted.
- R7: With `xtra_en` high at the end beat, the first-buffer size field of the first entry becomes the number of entries the packet used. With it low, that field is unchanged.
- R8: The ring pointer advances from entry DEPTH-1 to entry 0.
- R9: If a packet needs another entry while `cnt_level` is zero, its remaining bytes are accepted and discarded. No entry is claimed, and the writeback sets error=1 with length equal to the bytes actually stored.
- R10: When `ch_en` rises, the next claimed entry is entry 0, any open packet is abandoned without writeback, and `cnt_level` keeps its value.
- R11: `wb_valid` is high for the one cycle after the edge that accepted an end beat, with `wb_idx` giving the packet's first entry.
- R12: A beat without the start flag accepted while no packet is open is discarded and claims no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable; a rising edge restarts the ring |
| xtra_en | input | 1 | Replace first-buffer size with the entry count at writeback |
| in_valid | input | 1 | Stream beat valid (one byte) |
| in_ready | output | 1 | Stream beat ready |
| in_sop | input | 1 | Beat starts a packet |
| in_eop | input | 1 | Beat ends a packet |
| ld_en | input | 1 | Descriptor load strobe |
| ld_idx | input | IDX_W | Entry to load |
| ld_word | input | 30 | Descriptor word to load |
| rd_idx | input | IDX_W | Entry to read |
| rd_word | output | 30 | Descriptor word at `rd_idx` |
| cnt_add | input | 1 | Add credits this cycle |
| cnt_add_num | input | CNT_W | Number of credits to add |
| cnt_level | output | CNT_W | Descriptors currently granted and unclaimed |
| wb_valid | output | 1 | Status writeback occurred on the previous edge |
| wb_idx | output | IDX_W | Entry that received the writeback |

## Verification
`in_ready` is a function of the current state, so the bench reads it 1 ns after a falling edge without any clock delay. The descriptor store and `cnt_level` change on the very edge that accepts a beat. `wb_valid` and `wb_idx` are registered on that same edge, so all three are read at the falling edge that follows. Re-enabling the channel costs one cycle with `in_ready` low, and the bench checks that cycle before any beat is sent. Inputs change only at falling edges.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int SZ_W  = 8;
  localparam int LEN_W = 12;

  typedef struct packed {
    logic             done;
    logic             err;
    logic [LEN_W-1:0] len;
    logic [SZ_W-1:0]  size_b;
    logic [SZ_W-1:0]  size_a;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  function automatic logic [SZ_W:0] desc_cap(desc_t d);
    return {1'b0, d.size_a} + {1'b0, d.size_b};
  endfunction
endpackage

// File: rtl/rxd_desc_ram.sv
module rxd_desc_ram
  import rxd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  desc_t            ld_word,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic             wb_err,
  input  logic [LEN_W-1:0] wb_len,
  input  logic             wb_sz_en,
  input  logic [SZ_W-1:0]  wb_sz,
  input  logic [IDX_W-1:0] rd_a_idx,
  output desc_t            rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output desc_t            rd_b
);
  desc_t view [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    desc_t ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent <= '0;
      end else if (ld_en && ld_idx == IDX_W'(i)) begin
        ent <= ld_word;
      end else if (wb_en && wb_idx == IDX_W'(i)) begin
        ent.done <= 1'b1;
        ent.err  <= wb_err;
        ent.len  <= wb_len;
        if (wb_sz_en) ent.size_a <= wb_sz;
      end
    end
    assign view[i] = ent;
  end

  assign rd_a = view[rd_a_idx];
  assign rd_b = view[rd_b_idx];
endmodule

// File: rtl/rxd_ring_ctl.sv
module rxd_ring_ctl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             claim,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_num,
  output logic [IDX_W-1:0] head,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
    end else if (restart) begin
      head <= '0;
    end else if (claim) begin
      head <= (head == LAST) ? '0 : head + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + (add_en ? add_num : '0) - CNT_W'(claim);
  end
endmodule

// File: rtl/rxd_pkt_track.sv
module rxd_pkt_track
  import rxd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             beat,
  input  logic             sop,
  input  logic             eop,
  input  logic             xtra_en,
  input  logic             cnt_zero,
  input  logic [IDX_W-1:0] head,
  input  logic [SZ_W:0]    cap_cur,
  output logic             ready,
  output logic             claim,
  output logic [IDX_W-1:0] cur,
  output logic             open,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output logic             wb_err,
  output logic [LEN_W-1:0] wb_len,
  output logic             wb_sz_en,
  output logic [SZ_W-1:0]  wb_sz,
  output logic             wb_pulse_q,
  output logic [IDX_W-1:0] wb_idx_q
);
  logic [IDX_W-1:0] sop_idx, cur_n, sop_n;
  logic [SZ_W:0]    pos, pos_n;
  logic [LEN_W-1:0] len, len_n;
  logic [SZ_W-1:0]  nd, nd_n;
  logic             trunc, trunc_n, open_n, close;

  assign ready = run && (open || !cnt_zero);

  always_comb begin
    claim   = 1'b0;
    close   = 1'b0;
    open_n  = open;
    cur_n   = cur;
    sop_n   = sop_idx;
    pos_n   = pos;
    len_n   = len;
    nd_n    = nd;
    trunc_n = trunc;
    if (beat) begin
      if (!open) begin
        if (sop) begin
          claim   = 1'b1;
          cur_n   = head;
          sop_n   = head;
          pos_n   = (SZ_W+1)'(1);
          len_n   = LEN_W'(1);
          nd_n    = SZ_W'(1);
          trunc_n = 1'b0;
          open_n  = 1'b1;
          close   = eop;
        end
      end else begin
        if (trunc) begin
          trunc_n = 1'b1;
        end else if (pos < cap_cur) begin
          pos_n = pos + (SZ_W+1)'(1);
          len_n = len + LEN_W'(1);
        end else if (!cnt_zero) begin
          claim = 1'b1;
          cur_n = head;
          pos_n = (SZ_W+1)'(1);
          len_n = len + LEN_W'(1);
          nd_n  = nd + SZ_W'(1);
        end else begin
          trunc_n = 1'b1;
        end
        close = eop;
      end
      if (close) open_n = 1'b0;
    end
  end

  assign wb_en    = close;
  assign wb_idx   = sop_n;
  assign wb_err   = trunc_n;
  assign wb_len   = len_n;
  assign wb_sz_en = xtra_en;
  assign wb_sz    = nd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open    <= 1'b0;
      trunc   <= 1'b0;
      cur     <= '0;
      sop_idx <= '0;
      pos     <= '0;
      len     <= '0;
      nd      <= '0;
    end else if (restart) begin
      open  <= 1'b0;
      trunc <= 1'b0;
    end else begin
      open    <= open_n;
      trunc   <= trunc_n;
      cur     <= cur_n;
      sop_idx <= sop_n;
      pos     <= pos_n;
      len     <= len_n;
      nd      <= nd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_pulse_q <= 1'b0;
      wb_idx_q   <= '0;
    end else begin
      wb_pulse_q <= close;
      if (close) wb_idx_q <= sop_n;
    end
  end
endmodule

// File: rtl/rxdesc_status_writer.sv
module rxdesc_status_writer
  import rxd_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_en,
  input  logic              xtra_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DESC_W-1:0] ld_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DESC_W-1:0] rd_word,
  input  logic              cnt_add,
  input  logic [CNT_W-1:0]  cnt_add_num,
  output logic [CNT_W-1:0]  cnt_level,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx
);
  logic             ch_en_q, run, restart, beat, claim, pkt_open;
  logic [IDX_W-1:0] head_idx, cur_idx, wr_idx;
  logic             wr_en, wr_err, wr_sz_en;
  logic [LEN_W-1:0] wr_len;
  logic [SZ_W-1:0]  wr_sz;
  desc_t            sw_view, eng_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_en_q <= 1'b0;
    else        ch_en_q <= ch_en;
  end

  assign run     = ch_en && ch_en_q;
  assign restart = ch_en && !ch_en_q;
  assign beat    = in_valid && in_ready;

  rxd_desc_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_idx   (ld_idx),
    .ld_word  (desc_t'(ld_word)),
    .wb_en    (wr_en),
    .wb_idx   (wr_idx),
    .wb_err   (wr_err),
    .wb_len   (wr_len),
    .wb_sz_en (wr_sz_en),
    .wb_sz    (wr_sz),
    .rd_a_idx (rd_idx),
    .rd_a     (sw_view),
    .rd_b_idx (cur_idx),
    .rd_b     (eng_view)
  );

  rxd_ring_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .claim   (claim),
    .add_en  (cnt_add),
    .add_num (cnt_add_num),
    .head    (head_idx),
    .cnt     (cnt_level)
  );

  rxd_pkt_track #(.IDX_W(IDX_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .restart    (restart),
    .beat       (beat),
    .sop        (in_sop),
    .eop        (in_eop),
    .xtra_en    (xtra_en),
    .cnt_zero   (cnt_level == '0),
    .head       (head_idx),
    .cap_cur    (desc_cap(eng_view)),
    .ready      (in_ready),
    .claim      (claim),
    .cur        (cur_idx),
    .open       (pkt_open),
    .wb_en      (wr_en),
    .wb_idx     (wr_idx),
    .wb_err     (wr_err),
    .wb_len     (wr_len),
    .wb_sz_en   (wr_sz_en),
    .wb_sz      (wr_sz),
    .wb_pulse_q (wb_valid),
    .wb_idx_q   (wb_idx)
  );

  assign rd_word = sw_view;
endmodule

// File: rtl/rxdesc_status_writer_chk.sv
module rxdesc_status_writer_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_eop,
  input logic             cnt_add,
  input logic [CNT_W-1:0] cnt_level,
  input logic             wb_valid,
  input logic [IDX_W-1:0] head_idx,
  input logic             claim,
  input logic             pkt_open
);
  AST_OFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !in_ready); // R2
  AST_EMPTY_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_open && cnt_level == '0) |-> !in_ready); // R2
  AST_CLAIM_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> cnt_level != '0); // R3
  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_add |=> cnt_level <= $past(cnt_level)); // R3
  AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    32'(head_idx) < DEPTH); // R8
  AST_RESTART_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !$past(ch_en)) |=> head_idx == '0); // R10
  AST_WB_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(in_valid && in_ready && in_eop)); // R11
endmodule

bind rxdesc_status_writer rxdesc_status_writer_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_en     (ch_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eop    (in_eop),
  .cnt_add   (cnt_add),
  .cnt_level (cnt_level),
  .wb_valid  (wb_valid),
  .head_idx  (head_idx),
  .claim     (claim),
  .pkt_open  (pkt_open)
);

// File: tb/rxdesc_status_writer_bench.sv
`timescale 1ns/1ps
module rxdesc_status_writer_bench;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;
  localparam int DW    = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_en = 0, xtra_en = 0, in_valid = 0, in_sop = 0, in_eop = 0;
  logic ld_en = 0, cnt_add = 0;
  logic [IDX_W-1:0] ld_idx = '0, rd_idx = '0;
  logic [DW-1:0]    ld_word = '0;
  logic [CNT_W-1:0] cnt_add_num = '0;
  logic             in_ready, wb_valid;
  logic [DW-1:0]    rd_word;
  logic [CNT_W-1:0] cnt_level;
  logic [IDX_W-1:0] wb_idx;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  rxdesc_status_writer #(.DEPTH(DEPTH)) u_rxdesc_status_writer (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .xtra_en(xtra_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .rd_idx(rd_idx), .rd_word(rd_word),
    .cnt_add(cnt_add), .cnt_add_num(cnt_add_num), .cnt_level(cnt_level),
    .wb_valid(wb_valid), .wb_idx(wb_idx)
  );

  function automatic logic [DW-1:0] mk(input logic dn, input logic er,
                                       input int ln, input int sb, input int sa);
    return {dn, er, 12'(ln), 8'(sb), 8'(sa)};
  endfunction

  localparam logic [DW-1:0] FRESH = {1'b0, 1'b0, 12'd0, 8'd3, 8'd2};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input int idx, input logic [DW-1:0] exp);
    rd_idx = IDX_W'(idx);
    #0.5;
    chk(req, $sformatf("entry %0d", idx), 32'(rd_word), 32'(exp));
  endtask

  task automatic load(input int idx, input logic [DW-1:0] w);
    ld_en = 1; ld_idx = IDX_W'(idx); ld_word = w;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic add_credit(input int n);
    cnt_add = 1; cnt_add_num = CNT_W'(n);
    @(negedge clk);
    cnt_add = 0;
  endtask

  task automatic beat(input logic s, input logic e);
    int guard = 0;
    in_valid = 1; in_sop = s; in_eop = e;
    #1;
    while (!in_ready && guard < 50) begin
      @(negedge clk); #1; guard++;
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic send_pkt(input int n, input int exp_idx, input string req);
    for (int i = 0; i < n; i++) beat(i == 0, i == n - 1);
    chk("R11", "wb_valid after end beat", 32'(wb_valid), 32'd1);
    chk(req, "wb_idx", 32'(wb_idx), 32'(exp_idx));
  endtask

  task automatic t_reset;
    #1;
    chk("R2", "in_ready in reset state", 32'(in_ready), 32'd0);
    chk("R3", "cnt_level in reset state", 32'(cnt_level), 32'd0);
    chk("R11", "wb_valid in reset state", 32'(wb_valid), 32'd0);
  endtask

  task automatic t_setup;
    for (int i = 0; i < DEPTH; i++) load(i, FRESH);
    chk_word("R1", 3, FRESH);
    add_credit(8);
    chk("R3", "cnt_level after add", 32'(cnt_level), 32'd8);
    ch_en = 1;
    #1;
    chk("R2", "in_ready in first enabled cycle", 32'(in_ready), 32'd0);
    @(negedge clk);
    #1;
    chk("R2", "in_ready once running", 32'(in_ready), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_small;
    send_pkt(3, 0, "R5");
    chk_word("R5", 0, mk(1, 0, 3, 3, 2));
    chk("R3", "cnt after one entry", 32'(cnt_level), 32'd7);
    @(negedge clk);
    chk("R11", "wb_valid one cycle only", 32'(wb_valid), 32'd0);
  endtask

  task automatic t_fresh;
    send_pkt(2, 1, "R4");
    chk_word("R4", 1, mk(1, 0, 2, 3, 2));
    chk_word("R4", 0, mk(1, 0, 3, 3, 2));
    chk("R4", "cnt after second packet", 32'(cnt_level), 32'd6);
  endtask

  task automatic t_spill;
    xtra_en = 1;
    for (int i = 0; i < 11; i++) beat(i == 0, 1'b0);
    chk_word("R6", 2, FRESH);
    beat(1'b0, 1'b1);
    chk("R11", "wb_idx spill", 32'(wb_idx), 32'd2);
    chk_word("R7", 2, mk(1, 0, 12, 3, 3));
    chk_word("R5", 3, FRESH);
    chk_word("R5", 4, FRESH);
    chk("R3", "cnt after three entries", 32'(cnt_level), 32'd3);
    xtra_en = 0;
  endtask

  task automatic t_drop;
    beat(1'b0, 1'b0);
    chk("R12", "cnt after stray beat", 32'(cnt_level), 32'd3);
    chk_word("R12", 5, FRESH);
  endtask

  task automatic t_trunc;
    send_pkt(20, 5, "R12");
    chk_word("R9", 5, mk(1, 1, 15, 3, 2));
    chk_word("R9", 6, FRESH);
    chk("R9", "cnt drained", 32'(cnt_level), 32'd0);
  endtask

  task automatic t_stall_wrap;
    in_valid = 1; in_sop = 1;
    #1;
    chk("R2", "stall with no credit", 32'(in_ready), 32'd0);
    @(negedge clk); #1;
    chk("R2", "stall holds", 32'(in_ready), 32'd0);
    in_valid = 0; in_sop = 0;
    @(negedge clk);
    load(0, FRESH);
    load(1, FRESH);
    add_credit(2);
    send_pkt(1, 0, "R8");
    chk_word("R8", 0, mk(1, 0, 1, 3, 2));
    chk("R8", "cnt after wrap packet", 32'(cnt_level), 32'd1);
  endtask

  task automatic t_reenable;
    add_credit(1);
    beat(1'b1, 1'b0);
    beat(1'b0, 1'b0);
    chk("R10", "cnt before disable", 32'(cnt_level), 32'd1);
    ch_en = 0;
    @(negedge clk); #1;
    chk("R2", "in_ready while disabled", 32'(in_ready), 32'd0);
    @(negedge clk);
    load(0, FRESH);
    ch_en = 1;
    #1;
    chk("R2", "in_ready first cycle after enable", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R10", "cnt kept over enable", 32'(cnt_level), 32'd1);
    send_pkt(1, 0, "R10");
    chk_word("R10", 0, mk(1, 0, 1, 3, 2));
    chk_word("R10", 1, FRESH);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_setup;
    t_small;
    t_fresh;
    t_spill;
    t_drop;
    t_trunc;
    t_stall_wrap;
    t_reenable;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule